// File: doc/BRIEF.md
# Three-Multiplier Twiddle Complex Multiplier

This block rotates a signed fixed-point complex sample by one of N roots of unity, as a pipelined FFT stage needs between its butterflies. Each sample arrives with a valid strobe and a twiddle index k. The factor is C + jS with C = cos(2πk/N) and S = −sin(2πk/N). The block returns the product (X + jY)(C + jS), rounded and clipped back to the sample width, three clock cycles later.

Three real multipliers do the work instead of four. The block forms one shared term Z = C·(X − Y). The real part is (C − S)·Y + Z and the imaginary part is (C + S)·X − Z. The price is two extra coefficient tables, which hold C + S and C − S beside C. All three tables are filled when the design is built, from the parameters W and N. The difference X − Y and both coefficient sums carry one bit more than the sample, so no intermediate value can wrap.

Top module: `twiddle_cmul`

## Requirements
- R1: `out_vld` is `in_vld` delayed by exactly three clock cycles. Back-to-back and gapped samples keep their order and spacing.
- R2: The real output equals round((C·X − S·Y) / 2^(W−2)), where X = `in_re` and Y = `in_im` are taken in the cycle `in_vld` is high.
- R3: The imaginary output equals round((S·X + C·Y) / 2^(W−2)), for the same sample.
- R4: The coefficients are C = round(cos(2πk/N)·2^(W−2)) and S = round(−sin(2πk/N)·2^(W−2)), with k = `tw_idx` taken with the sample. In particular, k = 0 returns the input unchanged.
- R5: Rounding is to nearest with ties upward: 2^(W−3) is added before an arithmetic right shift by W−2. For example, with W=16 and k=1 of N=8, input (1, 0) gives (1, −1).
- R6: A result above 2^(W−1)−1 is clipped to 2^(W−1)−1. A result below −2^(W−1) is clipped to −2^(W−1).
- R7: While `rst_n` is low, `out_vld`, `out_re` and `out_im` are 0.
- R8: `out_re` and `out_im` keep their last value in every cycle in which `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample strobe |
| in_re | input | W | Sample real part X, signed |
| in_im | input | W | Sample imaginary part Y, signed |
| tw_idx | input | $clog2(N) | Twiddle index k |
| out_vld | output | 1 | Product strobe |
| out_re | output | W | Product real part, signed |
| out_im | output | W | Product imaginary part, signed |

## Verification
The hardest cases to reach are clipping and rounding ties. Both need a rotation near 45 degrees combined with full-scale or very small inputs, which ordinary random data seldom produces. The stimulus therefore drives index 1 with both inputs at the positive extreme and then at the negative extreme, to force both clipping limits. It also drives the single-LSB input (1, 0), where rounding and truncation give different answers. Random samples with random idle gaps then check ordering and the hold behaviour between results.

// File: rtl/twiddle_cmul.sv
module twiddle_cmul #(
  parameter int W = 16,
  parameter int N = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_vld,
  input  logic signed [W-1:0]          in_re,
  input  logic signed [W-1:0]          in_im,
  input  logic [$clog2(N)-1:0]         tw_idx,
  output logic                         out_vld,
  output logic signed [W-1:0]          out_re,
  output logic signed [W-1:0]          out_im
);
  localparam int  FB = W - 2;
  localparam int  MW = 2 * W + 1;
  localparam int  PW = 2 * W + 2;
  localparam real PI = 3.14159265358979323846;
  localparam logic signed [PW-1:0] RND  = PW'(1) << (FB - 1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) << (W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) << (W - 1));

  function automatic int rnd_q(input real r);
    real s;
    s = r * (2.0 ** FB);
    return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(0.5 - s);
  endfunction

  logic signed [W-1:0] rom_c [N];
  logic signed [W:0]   rom_p [N];
  logic signed [W:0]   rom_m [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    localparam int CI = rnd_q($cos(2.0 * PI * g / N));
    localparam int SI = rnd_q(-$sin(2.0 * PI * g / N));
    assign rom_c[g] = (W)'(CI);
    assign rom_p[g] = (W+1)'(CI + SI);
    assign rom_m[g] = (W+1)'(CI - SI);
  end

  logic                v1, v2;
  logic signed [W:0]   d1, p1, m1;
  logic signed [W-1:0] x1, y1, c1;
  logic signed [MW-1:0] z2, pr2, pi2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      v1 <= in_vld;
      v2 <= v1;
      out_vld <= v2;
    end

  always_ff @(posedge clk)
    if (in_vld) begin
      d1 <= {in_re[W-1], in_re} - {in_im[W-1], in_im};
      x1 <= in_re;
      y1 <= in_im;
      c1 <= rom_c[tw_idx];
      p1 <= rom_p[tw_idx];
      m1 <= rom_m[tw_idx];
    end

  always_ff @(posedge clk)
    if (v1) begin
      z2  <= c1 * d1;
      pr2 <= m1 * y1;
      pi2 <= p1 * x1;
    end

  logic signed [PW-1:0] sr, si, qr, qi;
  assign sr = PW'(pr2) + PW'(z2) + RND;
  assign si = PW'(pi2) - PW'(z2) + RND;
  assign qr = sr >>> FB;
  assign qi = si >>> FB;

  function automatic logic signed [W-1:0] clip(input logic signed [PW-1:0] v);
    if (v > MAXV) return MAXV[W-1:0];
    if (v < MINV) return MINV[W-1:0];
    return v[W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_re <= '0;
      out_im <= '0;
    end else if (v2) begin
      out_re <= clip(qr);
      out_im <= clip(qi);
    end

  AST_LATENCY_3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (out_vld == $past(in_vld, 3))); // R1

  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && out_vld && $past(tw_idx, 3) == '0)
    |-> (out_re == $past(in_re, 3) && out_im == $past(in_im, 3))); // R4

  AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && (qr > MAXV || qi > MAXV)) |=> (out_re == MAXV[W-1:0] || out_im == MAXV[W-1:0])); // R6

  AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && (qr < MINV || qi < MINV)) |=> (out_re == MINV[W-1:0] || out_im == MINV[W-1:0])); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> ($stable(out_re) && $stable(out_im))); // R8

  always_comb
    if (!rst_n) AST_RESET_QUIET: assert (!out_vld && out_re == '0 && out_im == '0); // R7
endmodule

// File: tb/twiddle_cmul_tb_top.sv
module twiddle_cmul_tb_top;
  localparam int W  = 16;
  localparam int N  = 8;
  localparam int KW = $clog2(N);
  localparam int FB = W - 2;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0;
  logic signed [W-1:0] in_re = '0, in_im = '0;
  logic [KW-1:0] tw_idx = '0;
  logic out_vld;
  logic signed [W-1:0] out_re, out_im;

  twiddle_cmul #(.W(W), .N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
    .tw_idx(tw_idx), .out_vld(out_vld), .out_re(out_re), .out_im(out_im));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint q_re[$], q_im[$], q_cyc[$];
  bit     q_exact[$];
  string  q_tag[$];

  function automatic longint rq(input real r);
    real s;
    s = r * (2.0 ** FB);
    return (s >= 0.0) ? longint'($rtoi(s + 0.5)) : -longint'($rtoi(0.5 - s));
  endfunction

  function automatic longint fit(input longint v);
    longint hi, lo, q;
    hi = (longint'(1) << (W - 1)) - 1;
    lo = -(longint'(1) << (W - 1));
    q = (v + (longint'(1) << (FB - 1))) >>> FB;
    if (q > hi) return hi;
    if (q < lo) return lo;
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int x, input int y, input int k, input bit exact, input string tag);
    longint c, s;
    c = rq($cos(2.0 * PI * k / N));
    s = rq(-$sin(2.0 * PI * k / N));
    @(negedge clk);
    in_vld = 1'b1; in_re = W'(x); in_im = W'(y); tw_idx = KW'(k);
    q_re.push_back(fit(c * x - s * y));
    q_im.push_back(fit(s * x + c * y));
    q_cyc.push_back(cyc);
    q_exact.push_back(exact);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  bit started = 0;
  logic signed [W-1:0] last_re = '0, last_im = '0;

  always @(negedge clk) if (rst_n) begin
    if (out_vld) begin
      if (q_re.size() == 0) check(0, "R1 unexpected output", 1, 0);
      else begin
        longint er, ei, ec, dr, di;
        bit ex;
        string tg;
        er = q_re.pop_front(); ei = q_im.pop_front(); ec = q_cyc.pop_front();
        ex = q_exact.pop_front(); tg = q_tag.pop_front();
        dr = longint'(out_re) - er; if (dr < 0) dr = -dr;
        di = longint'(out_im) - ei; if (di < 0) di = -di;
        check(ex ? dr == 0 : dr <= 1, {"R2 real ", tg}, longint'(out_re), er);
        check(ex ? di == 0 : di <= 1, {"R3 imag ", tg}, longint'(out_im), ei);
        check(cyc - ec == 3, "R1 latency", cyc - ec, 3);
      end
      started = 1;
    end else if (started) begin
      check(out_re == last_re && out_im == last_im, "R8 hold re/im", longint'(out_re), longint'(last_re));
    end
    last_re = out_re;
    last_im = out_im;
  end

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0 && out_re == '0 && out_im == '0, "R7 reset outputs", longint'(out_re), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    // R4: index 0 passes the sample through
    send(1234, -567, 0, 1, "R4 unity");
    send(32767, -32768, 0, 1, "R4 unity extremes");
    send(-32768, 32767, 0, 1, "R4 unity extremes");
    idle(3);
    // R2 R3: every index, one fixed sample, back to back
    for (int k = 0; k < N; k++) send(10000, -7000, k, 1, "R4 sweep");
    idle(2);
    // R5: single-LSB input where rounding differs from truncation
    send(1, 0, 1, 1, "R5 round");
    send(0, 1, 1, 1, "R5 round");
    send(3, 5, 3, 1, "R5 round");
    idle(4);
    // R6: clipping at both limits
    send(32767, 32767, 1, 1, "R6 clip high");
    send(-32768, -32768, 1, 1, "R6 clip low");
    send(-32768, 32767, 7, 1, "R6 clip");
    idle(5);
    // random samples with random gaps
    for (int i = 0; i < 400; i++) begin
      send(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
           int'($urandom_range(0, N - 1)), 0, "R1 random");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 4)));
    end
    idle(10);
    check(q_re.size() == 0, "R1 all results returned", q_re.size(), 0);
    report();
  end
endmodule